// File: doc/BRIEF.md
# Nonvolatile Settings Commit Controller

This block sits beside a register-access slave and keeps a small nonvolatile store in step with a set of live configuration registers. By default these are two wiper positions and one gain byte. Each accepted data write from the slave marks its register as changed. A special index stands for "both wipers" and marks every wiper register at once. When the transfer ends with a stop condition, write protection is off and something has changed, the block copies only the changed registers into the store. It copies one register per clock, in ascending index order. It then holds a timed write window. For the whole sequence it raises `busy`, which the slave uses to refuse its address so that a master can poll. A start condition that arrives before the stop throws the changes away. The live registers keep their new values, which gives a volatile-only update path.

After reset the block waits a startup delay and then recalls each stored value into the live registers. It does this through a load strobe, one register per clock. A store location that has never been written counts as blank. For a blank location the recall loads the default value (1Fh for each wiper, 11h for gain) and writes that default into the store. The store is modelled inside the block as a register array that keeps its contents across `rst_n`. Its write port is brought out so it can be observed.

Top module: `nv_commit_ctrl`

## Requirements
- R1: From reset release, `busy` stays high for STARTUP_CYC + NREG clock edges. After the first STARTUP_CYC edges, `rcl_load` pulses once per register, with `rcl_idx` rising 0, 1, …, NREG-1, one per clock.
- R2: During recall, a blank store location gives `rcl_data` equal to its default (index 0 = 1Fh, index 1 = 1Fh, index 2 = 11h). In the same cycle that default is written to the store (`st_we`, `st_addr` = index, `st_wdata` = default).
- R3: A stop while idle, with `wp_lock` low and at least one changed register, writes each changed register to the store exactly once. The writes go in ascending index order, one per clock, and `st_wdata` is that register's `live_vals` byte (bits [8i+7:8i]) in the write cycle.
- R4: After such a stop, `busy` rises at the next clock edge and stays high for exactly NREG + WRITE_CYC cycles.
- R5: A start pulse while idle discards every change flag. A stop that follows writes nothing and leaves `busy` low.
- R6: A stop with `wp_lock` high writes nothing, leaves `busy` low and discards the change flags, so a later stop with `wp_lock` low also writes nothing.
- R7: A write with `wr_idx` = NREG (3 by default) marks every wiper register (indices 0 to NWIPER-1) and no other register.
- R8: A stop while idle with no changed register writes nothing and leaves `busy` low.
- R9: While `busy` is high, `wr_evt`, `evt_start` and `evt_stop` have no effect. They neither lengthen the current busy period nor leave anything pending.
- R10: `st_we` and `rcl_load` are only ever high while `busy` is high, and `st_addr` is always below NREG when `st_we` is high.
- R11: A recall after a later reset returns the values last written to the store and issues no store write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts the startup delay and recall |
| evt_start | input | 1 | One-cycle pulse on a start or repeated start condition |
| evt_stop | input | 1 | One-cycle pulse on a stop condition |
| wr_evt | input | 1 | One-cycle pulse when the slave accepts a data byte |
| wr_idx | input | IW | Register index of that write; NREG means all wipers |
| wp_lock | input | 1 | Write-protect level; high blocks persistence |
| live_vals | input | NREG*DW | Current live register values, index i at bits [DW*i+DW-1:DW*i] |
| busy | output | 1 | High during startup, recall and commit |
| rcl_load | output | 1 | Strobe: load `rcl_data` into live register `rcl_idx` |
| rcl_idx | output | IW | Register index being recalled |
| rcl_data | output | DW | Recalled value |
| st_we | output | 1 | Store write enable |
| st_addr | output | IW | Store write address |
| st_wdata | output | DW | Store write data |

## Verification
The bench aims at the abandon paths:
- A start before the stop. A design that commits anyway would show a store write and a busy period.
- A write-protected stop. A design that keeps the change flags would persist them on the next unprotected stop.

The dual-wiper index is exercised because an off-by-one decode would mark the gain register too.

Two ordered writes are checked for their capture cycle. Live values are changed after the writes and before the stop. A design that latched data at write time would store stale bytes.

Events are injected mid-commit. A design that honoured them would show a longer busy period or a second commit.

A second reset checks that recall returns the committed bytes and does not rewrite defaults.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
   typedef enum logic [2:0] {
      ST_BOOT   = 3'd0,
      ST_RECALL = 3'd1,
      ST_IDLE   = 3'd2,
      ST_COMMIT = 3'd3,
      ST_WAIT   = 3'd4
   } nvc_state_e;
endpackage

// File: rtl/nvc_dirty.sv
module nvc_dirty #(
   parameter int NREG   = 3,
   parameter int NWIPER = 2,
   parameter int IW     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            wr_evt,
   input  logic [IW-1:0]   wr_idx,
   input  logic            clr,
   output logic [NREG-1:0] dirty
);
   // changed-register flags; the all-wiper index sets a whole group
   for (genvar i = 0; i < NREG; i++) begin : g_flag
      logic hit;
      if (i < NWIPER) begin : g_wiper
         assign hit = (wr_idx == IW'(i)) || (wr_idx == IW'(NREG));
      end else begin : g_plain
         assign hit = (wr_idx == IW'(i));
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dirty[i] <= 1'b0;
         else if (accept && wr_evt && hit) dirty[i] <= 1'b1;
         else if (accept && clr)       dirty[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/nvc_store.sv
module nvc_store #(
   parameter int NREG = 3,
   parameter int DW   = 8,
   parameter int IW   = 2
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] raddr,
   output logic          rvld,
   output logic [DW-1:0] rdata
);
   // persistent cells: deliberately not cleared by the logic reset
   logic [DW-1:0] cell_q [NREG];
   logic          vld_q  [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (we && waddr == IW'(i)) begin
            cell_q[i] <= wdata;
            vld_q[i]  <= 1'b1;
         end
      end
   end

   always_comb begin
      rvld  = 1'b0;
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (raddr == IW'(i)) begin
            rvld  = vld_q[i];
            rdata = cell_q[i];
         end
      end
   end
endmodule

// File: rtl/nvc_seq.sv
module nvc_seq
   import nvc_pkg::*;
#(
   parameter int NREG        = 3,
   parameter int IW          = 2,
   parameter int STARTUP_CYC = 5000,
   parameter int WRITE_CYC   = 2500000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_stop,
   input  logic            wp_lock,
   input  logic [NREG-1:0] dirty,
   output nvc_state_e      state,
   output logic [IW-1:0]   idx,
   output logic [NREG-1:0] snap
);
   localparam int MAXC = (STARTUP_CYC > WRITE_CYC) ? STARTUP_CYC : WRITE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   wire last_idx = (idx == IW'(NREG - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_BOOT;
         cnt   <= '0;
         idx   <= '0;
         snap  <= '0;
      end else begin
         unique case (state)
            ST_BOOT: begin
               if (cnt == CW'(STARTUP_CYC - 1)) begin
                  state <= ST_RECALL;
                  cnt   <= '0;
                  idx   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            ST_RECALL: begin
               if (last_idx) begin
                  state <= ST_IDLE;
                  idx   <= '0;
               end else idx <= idx + 1'b1;
            end
            ST_IDLE: begin
               if (evt_stop && !wp_lock && (|dirty)) begin
                  state <= ST_COMMIT;
                  snap  <= dirty;
                  idx   <= '0;
               end
            end
            ST_COMMIT: begin
               if (last_idx) begin
                  state <= ST_WAIT;
                  cnt   <= '0;
                  idx   <= '0;
               end else idx <= idx + 1'b1;
            end
            ST_WAIT: begin
               if (cnt == CW'(WRITE_CYC - 1)) state <= ST_IDLE;
               else                           cnt   <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
   import nvc_pkg::*;
#(
   parameter int                      NREG        = 3,
   parameter int                      DW          = 8,
   parameter int                      NWIPER      = 2,
   parameter int                      STARTUP_CYC = 5000,
   parameter int                      WRITE_CYC   = 2500000,
   parameter logic [NREG*DW-1:0]      DEF_VALS    = 24'h11_1F_1F,
   localparam int                     IW          = $clog2(NREG + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_start,
   input  logic               evt_stop,
   input  logic               wr_evt,
   input  logic [IW-1:0]      wr_idx,
   input  logic               wp_lock,
   input  logic [NREG*DW-1:0] live_vals,
   output logic               busy,
   output logic               rcl_load,
   output logic [IW-1:0]      rcl_idx,
   output logic [DW-1:0]      rcl_data,
   output logic               st_we,
   output logic [IW-1:0]      st_addr,
   output logic [DW-1:0]      st_wdata
);
   if (NREG < 1 || NWIPER < 1 || NWIPER > NREG) begin : g_bad_regs
      $error("nv_commit_ctrl: need 1 <= NWIPER <= NREG");
   end
   if (STARTUP_CYC < 1 || WRITE_CYC < 1) begin : g_bad_cyc
      $error("nv_commit_ctrl: cycle counts must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("nv_commit_ctrl: DW must be positive");
   end

   nvc_state_e      state;
   logic [IW-1:0]   idx;
   logic [NREG-1:0] snap, dirty;
   logic            st_vld;
   logic [DW-1:0]   st_rdata, live_sel, def_sel;

   wire idle = (state == ST_IDLE);

   nvc_dirty #(.NREG(NREG), .NWIPER(NWIPER), .IW(IW)) u_dirty (
      .clk(clk), .rst_n(rst_n), .accept(idle), .wr_evt(wr_evt),
      .wr_idx(wr_idx), .clr(evt_start | evt_stop), .dirty(dirty)
   );

   nvc_seq #(.NREG(NREG), .IW(IW), .STARTUP_CYC(STARTUP_CYC),
             .WRITE_CYC(WRITE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .evt_stop(evt_stop), .wp_lock(wp_lock),
      .dirty(dirty), .state(state), .idx(idx), .snap(snap)
   );

   nvc_store #(.NREG(NREG), .DW(DW), .IW(IW)) u_store (
      .clk(clk), .we(st_we), .waddr(st_addr), .wdata(st_wdata),
      .raddr(idx), .rvld(st_vld), .rdata(st_rdata)
   );

   always_comb begin
      live_sel = '0;
      def_sel  = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IW'(i)) begin
            live_sel = live_vals[i*DW +: DW];
            def_sel  = DEF_VALS[i*DW +: DW];
         end
      end
   end

   logic snap_sel;
   always_comb begin
      snap_sel = 1'b0;
      for (int i = 0; i < NREG; i++)
         if (idx == IW'(i)) snap_sel = snap[i];
   end

   assign busy     = !idle;
   assign rcl_load = (state == ST_RECALL);
   assign rcl_idx  = idx;
   assign rcl_data = st_vld ? st_rdata : def_sel;
   assign st_we    = (rcl_load && !st_vld) || (state == ST_COMMIT && snap_sel);
   assign st_addr  = idx;
   assign st_wdata = rcl_load ? def_sel : live_sel;
endmodule

// File: rtl/nvc_chk.sv
module nvc_chk #(
   parameter int NREG = 3,
   parameter int IW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          evt_start,
   input logic          evt_stop,
   input logic          wp_lock,
   input logic          busy,
   input logic          rcl_load,
   input logic          st_we,
   input logic [IW-1:0] st_addr
);
   assert_store_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> busy);
   assert_recall_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rcl_load |-> busy);
   assert_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> (st_addr < IW'(NREG)));
   assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_stop && wp_lock && !busy) |=> !busy);
   assert_start_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_start && !evt_stop && !busy) |=> !busy);
   assert_busy_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !rcl_load);
endmodule

bind nv_commit_ctrl nvc_chk #(.NREG(NREG), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
   .wp_lock(wp_lock), .busy(busy), .rcl_load(rcl_load), .st_we(st_we),
   .st_addr(st_addr)
);

// File: tb/tb_nv_commit_ctrl.sv
module tb_nv_commit_ctrl;
   localparam int NREG = 3, DW = 8, IW = 2, SC = 20, WC = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt_start = 0, evt_stop = 0, wr_evt = 0, wp_lock = 0;
   logic [IW-1:0] wr_idx = '0;
   logic [NREG*DW-1:0] live = '0;
   logic busy, rcl_load, st_we;
   logic [IW-1:0] rcl_idx, st_addr;
   logic [DW-1:0] rcl_data, st_wdata;

   always #4 clk = ~clk;

   nv_commit_ctrl #(.NREG(NREG), .DW(DW), .NWIPER(2), .STARTUP_CYC(SC),
                    .WRITE_CYC(WC)) dut (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
      .wr_evt(wr_evt), .wr_idx(wr_idx), .wp_lock(wp_lock), .live_vals(live),
      .busy(busy), .rcl_load(rcl_load), .rcl_idx(rcl_idx), .rcl_data(rcl_data),
      .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata)
   );

   int total = 0, bad = 0;
   int busy_cnt, we_n, rc_n;
   int we_a [16], we_d [16], rc_i [16], rc_d [16];
   int exp_store [NREG];

   // sample 2 ns after each rising edge, drive at falling edges
   always begin
      @(posedge clk); #2;
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (st_we && we_n < 16) begin we_a[we_n] = st_addr; we_d[we_n] = st_wdata; we_n++; end
         if (rcl_load && rc_n < 16) begin rc_i[rc_n] = rcl_idx; rc_d[rc_n] = rcl_data; rc_n++; end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      busy_cnt = 0; we_n = 0; rc_n = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic pulse_wr(input int i);
      wr_idx = IW'(i); wr_evt = 1; @(negedge clk); wr_evt = 0;
   endtask
   task automatic pulse_stop();
      evt_stop = 1; @(negedge clk); evt_stop = 0;
   endtask
   task automatic pulse_start();
      evt_start = 1; @(negedge clk); evt_start = 0;
   endtask
   task automatic set_live(input int i, input int v);
      live[i*DW +: DW] = DW'(v);
   endtask

   task automatic expect_quiet(input string tag);
      repeat (4) @(negedge clk);
      check(we_n == 0, {tag, " no store write"}, we_n, 0);
      check(busy_cnt == 0, {tag, " busy stays low"}, busy_cnt, 0);
   endtask

   task automatic t_power_up();
      @(negedge clk);
      check(busy == 1'b1, "R1 busy in reset", busy, 1);
      clear_log();
      rst_n = 1;
      wait_idle();
      // busy sampled after edges 1..SC+NREG-1; idle after edge SC+NREG (R1)
      check(busy_cnt == SC + NREG - 1, "R1 startup busy length", busy_cnt, SC + NREG - 1);
      check(rc_n == NREG, "R1 recall strobes", rc_n, NREG);
      for (int i = 0; i < NREG; i++) begin
         int dv = (i == 2) ? 'h11 : 'h1F;
         check(rc_i[i] == i, "R1 recall order", rc_i[i], i);
         check(rc_d[i] == dv, "R2 blank default loaded", rc_d[i], dv);
         check(we_a[i] == i && we_d[i] == dv, "R2 default written to store", we_d[i], dv);
         exp_store[i] = dv;
      end
      check(we_n == NREG, "R2 default write count", we_n, NREG);
   endtask

   task automatic t_nv_write();
      set_live(0, 'h05); set_live(1, 'h2A); set_live(2, 'h44);
      clear_log();
      pulse_wr(1); pulse_stop(); wait_idle();
      check(we_n == 1, "R3 single dirty write count", we_n, 1);
      check(we_a[0] == 1 && we_d[0] == 'h2A, "R3 written data", we_d[0], 'h2A);
      check(busy_cnt == NREG + WC, "R4 commit busy length", busy_cnt, NREG + WC);
      exp_store[1] = 'h2A;
   endtask

   task automatic t_volatile();
      clear_log();
      pulse_wr(0); pulse_start(); pulse_stop();
      expect_quiet("R5 repeated start");
      clear_log();
      pulse_stop();
      expect_quiet("R8 stop with nothing dirty");
   endtask

   task automatic t_dual();
      set_live(0, 'h07); set_live(1, 'h3C);
      clear_log();
      pulse_wr(NREG); pulse_stop(); wait_idle();
      check(we_n == 2, "R7 dual index write count", we_n, 2);
      check(we_a[0] == 0 && we_d[0] == 'h07, "R7 wiper0 written", we_d[0], 'h07);
      check(we_a[1] == 1 && we_d[1] == 'h3C, "R7 wiper1 written", we_d[1], 'h3C);
      exp_store[0] = 'h07; exp_store[1] = 'h3C;
   endtask

   task automatic t_protect();
      clear_log();
      wp_lock = 1;
      pulse_wr(2); pulse_stop();
      expect_quiet("R6 protected stop");
      wp_lock = 0;
      clear_log();
      pulse_stop();
      expect_quiet("R6 flags discarded");
   endtask

   task automatic t_order_capture();
      clear_log();
      pulse_wr(2); pulse_wr(0);
      set_live(2, 'h12); set_live(0, 'h15);
      pulse_stop(); wait_idle();
      check(we_n == 2, "R3 two dirty write count", we_n, 2);
      check(we_a[0] == 0 && we_d[0] == 'h15, "R3 first write index0 live data", we_d[0], 'h15);
      check(we_a[1] == 2 && we_d[1] == 'h12, "R3 second write index2 live data", we_d[1], 'h12);
      exp_store[0] = 'h15; exp_store[2] = 'h12;
   endtask

   task automatic t_busy_ignore();
      set_live(1, 'h09);
      clear_log();
      pulse_wr(1); pulse_stop();
      repeat (5) @(negedge clk);
      pulse_wr(0); pulse_start(); pulse_stop();
      wait_idle();
      check(we_n == 1, "R9 events during busy ignored", we_n, 1);
      check(busy_cnt == NREG + WC, "R9 busy not extended", busy_cnt, NREG + WC);
      exp_store[1] = 'h09;
      clear_log();
      pulse_stop();
      expect_quiet("R9 nothing pending");
   endtask

   task automatic t_persist();
      rst_n = 0;
      repeat (3) @(negedge clk);
      clear_log();
      rst_n = 1;
      wait_idle();
      check(rc_n == NREG, "R11 recall strobes", rc_n, NREG);
      for (int i = 0; i < NREG; i++)
         check(rc_d[i] == exp_store[i], "R11 recalled stored value", rc_d[i], exp_store[i]);
      check(we_n == 0, "R11 no store write on recall", we_n, 0);
   endtask

   bit done = 0;
   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      clear_log();
      repeat (3) @(negedge clk);
      t_power_up();
      t_nv_write();
      t_volatile();
      t_dual();
      t_protect();
      t_order_capture();
      t_busy_ignore();
      t_persist();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule